// File: doc/BRIEF.md
# Accumulating Averaging Result Register

This block sits behind one sample channel of a 12-bit converter and in front of its 16-bit result register. Each conversion-done strobe brings a 12-bit code. The block adds these codes into a wide running sum for a group of 2^k conversions, where k is programmed. At the end of the group it stores one value in the result register. That value is either the raw sum, scaled down when needed so that it fits 16 bits, or the average of the group. A single 12-bit value can be placed in the low or the high end of the result word.

Partial sums stay internal, so the result register changes once per finished group. A valid flag tells a reader that an unread value is waiting. A sticky overrun flag shows that an unread value was overwritten. A one-cycle ready pulse, gated by an enable, can request a DMA transfer or raise an interrupt for each new result.

Top module: `acc_avg_result`

## Requirements
- R1: After reset, result is 0 and valid, overrun and ready_pulse are 0.
- R2: A group is 2^acc_sel conversions for acc_sel 0 to 8, and any acc_sel above 8 acts as 8. The result, valid and ready_pulse change only in the cycle after the strobe of the last conversion of a group. Earlier conversions of the group leave them unchanged.
- R3: With avg_en low and acc_sel from 1 to 8, the stored value is the 16-bit group sum. For acc_sel 5, 6, 7 and 8 the sum is first shifted right by 1, 2, 3 and 4 bits. For acc_sel 1 to 4 it is stored unshifted. align_left has no effect in this mode.
- R4: With avg_en high, the stored 12-bit value is the group sum divided by 2^acc_sel, rounded down.
- R5: A 12-bit value (avg_en high, or acc_sel 0) goes to result[11:0] with bits [15:12] zero when align_left is 0. It goes to result[15:4] with bits [3:0] zero when align_left is 1.
- R6: Every stored result sets valid. A cycle with rd_stb high and no store clears valid. A store in the same cycle as rd_stb leaves valid set.
- R7: overrun sets when a result is stored while valid is set and rd_stb is low in that cycle. Only ovr_clr clears it, and a store that sets it wins over ovr_clr in the same cycle.
- R8: ready_pulse is high for exactly the cycle in which a new result appears, and only if ready_en was high on the last conversion's strobe.
- R9: A cycle in which acc_sel differs from its value in the previous cycle discards the partial sum, restarts the group count and ignores any conversion in that cycle. The value held during reset counts as 0.
- R10: A cycle without conv_done changes neither the result nor the group state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_done | input | 1 | A conversion finished this cycle |
| conv_data | input | 12 | Converter code, valid with conv_done |
| acc_sel | input | 4 | Group size exponent, group = 2^acc_sel conversions |
| avg_en | input | 1 | Store the group average instead of the sum |
| align_left | input | 1 | Place 12-bit values in bits [15:4] |
| ready_en | input | 1 | Enables ready_pulse |
| rd_stb | input | 1 | The result is being read this cycle |
| ovr_clr | input | 1 | Clears the overrun flag |
| result | output | 16 | Stored result |
| valid | output | 1 | An unread result is present |
| overrun | output | 1 | An unread result was overwritten |
| ready_pulse | output | 1 | One-cycle new-result request |

## Verification
The bench uses the default parameters: a 12-bit code, a 16-bit result and a largest group of 256 conversions. With these values the largest group can be filled with full-scale codes. That reaches the 20-bit sum of 256 × 4095, the 4-bit scaling down to 65520, and an average of exactly 4095. Directed groups at every shift boundary are followed by a long random phase. In that phase reads, overrun clears and configuration changes land in the middle of groups and in the same cycle as stores, and a behavioural model is compared against the design every cycle.

// File: rtl/acc_avg_result.sv
module acc_avg_result #(
  parameter int CONV_W  = 12,
  parameter int RES_W   = 16,
  parameter int MAX_SEL = 8,
  parameter int SEL_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [CONV_W-1:0] conv_data,
  input  logic [SEL_W-1:0]  acc_sel,
  input  logic              avg_en,
  input  logic              align_left,
  input  logic              ready_en,
  input  logic              rd_stb,
  input  logic              ovr_clr,
  output logic [RES_W-1:0]  result,
  output logic              valid,
  output logic              overrun,
  output logic              ready_pulse
);
  localparam int ACC_W = CONV_W + MAX_SEL;
  localparam int HEAD  = RES_W - CONV_W;

  logic [SEL_W-1:0]   sel_q;
  logic [ACC_W-1:0]   sum_q;
  logic [MAX_SEL-1:0] cnt_q;

  wire [SEL_W-1:0] sel_eff = (acc_sel > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : acc_sel;
  wire             cfg_chg = acc_sel != sel_q;
  wire [ACC_W-1:0] total   = sum_q + ACC_W'(conv_data);
  wire [MAX_SEL:0] grp_len = (MAX_SEL+1)'(1) << sel_eff;
  wire             last    = conv_done && !cfg_chg && ({1'b0, cnt_q} == grp_len - 1'b1);

  wire [CONV_W-1:0] v12    = CONV_W'(total >> sel_eff);
  wire [RES_W-1:0]  fmt12  = align_left ? {v12, {HEAD{1'b0}}} : {{HEAD{1'b0}}, v12};
  wire [RES_W-1:0]  raw16  = (sel_eff > SEL_W'(HEAD)) ? RES_W'(total >> (sel_eff - SEL_W'(HEAD)))
                                                      : RES_W'(total);
  wire              narrow = avg_en || (sel_eff == '0);
  wire [RES_W-1:0]  next_r = narrow ? fmt12 : raw16;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      sum_q <= '0;
      cnt_q <= '0;
    end else begin
      sel_q <= acc_sel;
      if (cfg_chg || last) begin
        sum_q <= '0;
        cnt_q <= '0;
      end else if (conv_done) begin
        sum_q <= total;
        cnt_q <= cnt_q + MAX_SEL'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result      <= '0;
      valid       <= 1'b0;
      overrun     <= 1'b0;
      ready_pulse <= 1'b0;
    end else begin
      ready_pulse <= last && ready_en;
      if (last) result <= next_r;
      if (last) valid <= 1'b1;
      else if (rd_stb) valid <= 1'b0;
      if (last && valid && !rd_stb) overrun <= 1'b1;
      else if (ovr_clr) overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/acc_avg_result_chk.sv
module acc_avg_result_chk #(
  parameter int CONV_W  = 12,
  parameter int RES_W   = 16,
  parameter int SEL_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             conv_done,
  input logic [SEL_W-1:0] acc_sel,
  input logic             avg_en,
  input logic             align_left,
  input logic             ready_en,
  input logic             ovr_clr,
  input logic [RES_W-1:0] result,
  input logic             valid,
  input logic             overrun,
  input logic             ready_pulse
);
  localparam int HEAD = RES_W - CONV_W;

  p_ready_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready_pulse |-> $past(ready_en) && $past(conv_done));

  p_store_sets_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> valid);

  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(overrun) && !$past(ovr_clr)) |-> overrun);

  p_avg_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(result) && $past(avg_en) && !$past(align_left)) |-> result[RES_W-1:CONV_W] == '0);

  p_left_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(result) && $past(align_left) && ($past(avg_en) || $past(acc_sel) == '0))
      |-> result[HEAD-1:0] == '0);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(conv_done) |-> $stable(result) && !ready_pulse);
endmodule

bind acc_avg_result acc_avg_result_chk #(.CONV_W(CONV_W), .RES_W(RES_W), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/acc_avg_result_tb.sv
module acc_avg_result_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic [3:0]  acc_sel = '0;
  logic        avg_en = 1'b0;
  logic        align_left = 1'b0;
  logic        ready_en = 1'b0;
  logic        rd_stb = 1'b0;
  logic        ovr_clr = 1'b0;
  logic [15:0] result;
  logic        valid, overrun, ready_pulse;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int m_sum, m_cnt, m_prev, m_res;
  bit m_val, m_ovr, m_rdy;

  always #4 clk = ~clk;

  acc_avg_result u_dut (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
    .acc_sel(acc_sel), .avg_en(avg_en), .align_left(align_left), .ready_en(ready_en),
    .rd_stb(rd_stb), .ovr_clr(ovr_clr), .result(result), .valid(valid),
    .overrun(overrun), .ready_pulse(ready_pulse)
  );

  function automatic int stored(int t, int k, bit avg, bit left);
    int v;
    if (avg || k == 0) begin
      v = t / (1 << k);
      if (left) v = v * 16;
    end else if (k > 4) v = t / (1 << (k - 4));
    else v = t;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sum = 0; m_cnt = 0; m_prev = 0; m_res = 0;
      m_val = 0; m_ovr = 0; m_rdy = 0;
    end else begin
      int k;
      bit wr;
      wr = 0;
      k = (acc_sel > 8) ? 8 : int'(acc_sel);
      m_rdy = 0;
      if (int'(acc_sel) != m_prev) begin
        m_sum = 0; m_cnt = 0;
      end else if (conv_done) begin
        if (m_cnt + 1 == (1 << k)) begin
          m_res = stored(m_sum + int'(conv_data), k, avg_en, align_left);
          m_sum = 0; m_cnt = 0; wr = 1;
          m_rdy = ready_en;
        end else begin
          m_sum += int'(conv_data); m_cnt++;
        end
      end
      m_prev = int'(acc_sel);
      if (wr && m_val && !rd_stb) m_ovr = 1;
      else if (ovr_clr) m_ovr = 0;
      if (wr) m_val = 1;
      else if (rd_stb) m_val = 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 result", int'(result), m_res);
      chk("R6 valid", int'(valid), int'(m_val));
      chk("R7 overrun", int'(overrun), int'(m_ovr));
      chk("R8 ready_pulse", int'(ready_pulse), int'(m_rdy));
    end
  end

  task automatic step(input bit c, input int d, input bit r, input bit k);
    conv_done = c; conv_data = 12'(d); rd_stb = r; ovr_clr = k;
    @(negedge clk);
    conv_done = 0; rd_stb = 0; ovr_clr = 0;
  endtask

  task automatic run_group(input int sel, input bit avg, input bit left, input int mode);
    int n;
    acc_sel = 4'(sel); avg_en = avg; align_left = left;
    step(0, 0, 0, 0);
    n = 1 << ((sel > 8) ? 8 : sel);
    for (int i = 0; i < n; i++) begin
      int d;
      d = (mode == 0) ? 4095 : (mode == 1) ? (i * 37 + 5) % 4096 : int'($urandom % 4096);
      step(1, d, 0, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 result", int'(result), 0);
    chk("R1 valid", int'(valid), 0);
    chk("R1 overrun", int'(overrun), 0);
    chk("R1 ready", int'(ready_pulse), 0);
    ready_en = 1;

    run_group(0, 0, 0, 1);
    run_group(0, 0, 1, 1);
    chk("R5 left", int'(result), (((8*37+5)%4096) * 0) + ((0*37+5) * 16));
    step(0, 0, 1, 0);
    run_group(2, 0, 1, 1);
    run_group(4, 0, 0, 0);
    chk("R3 sum16", int'(result), 65520);
    run_group(5, 0, 0, 2);
    run_group(8, 0, 1, 0);
    chk("R3 shift4", int'(result), 65520);
    run_group(8, 1, 0, 2);
    run_group(3, 1, 1, 1);
    run_group(12, 1, 0, 0);
    chk("R2 clamp", int'(result), 4095);
    run_group(6, 0, 0, 2);
    run_group(7, 1, 1, 2);

    // overrun and clear
    acc_sel = 0; avg_en = 0; align_left = 0;
    step(0, 0, 1, 0);
    step(1, 7, 0, 0);
    step(1, 9, 0, 0);
    chk("R7 set", int'(overrun), 1);
    step(0, 0, 0, 1);
    chk("R7 clear", int'(overrun), 0);
    step(1, 3, 1, 0);
    chk("R7 read wins", int'(overrun), 0);
    chk("R6 store+read", int'(valid), 1);

    // restart on configuration change
    acc_sel = 2; step(0, 0, 0, 0);
    step(1, 100, 0, 0); step(1, 200, 0, 0);
    acc_sel = 1; step(1, 999, 0, 0);
    step(1, 10, 0, 0); step(1, 20, 0, 0);
    chk("R9 restart", int'(result), 30);

    ready_en = 0;
    run_group(1, 0, 0, 2);
    chk("R8 gated", int'(ready_pulse), 0);
    ready_en = 1;

    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 300 == 0) acc_sel = 4'($urandom % 10);
      if ($urandom % 50 == 0) avg_en = 1'($urandom);
      if ($urandom % 50 == 0) align_left = 1'($urandom);
      if ($urandom % 40 == 0) ready_en = 1'($urandom);
      step(1'($urandom % 3 != 0), int'($urandom % 4096),
           1'($urandom % 5 == 0), 1'($urandom % 7 == 0));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule